// File: doc/BRIEF.md
# Packed Unsigned Minimum Locator

This unit takes a 128-bit operand, views it as eight unsigned 16-bit lanes, and finds the smallest lane value together with the number of the lane that holds it. Both answers go into a 128-bit result word with a fixed layout. The value sits in the bottom 16 bits and the lane number in the 16 bits above it. Every higher bit reads zero.

The search runs as a binary tree of pairwise comparisons, three levels deep. A register sits after each level. A new operand may be presented on every clock cycle. Each answer leaves the unit a fixed number of cycles later, with a valid strobe that has moved through the same registers as the data. When several lanes share the smallest value, the lowest-numbered lane wins.

Top module: `minpos_unit`

## Requirements
- R1: Lane i of the operand is bits 16*i+15 down to 16*i of `in_src`, for i from 0 to 7.
- R2: Result bits 15:0 hold the smallest lane value, compared as unsigned, so 16'hFFFF ranks above every other value.
- R3: Result bits 18:16 hold the number of the lane holding the smallest value, and bits 31:19 are zero.
- R4: Result bits 127:32 are zero whenever `out_valid` is high.
- R5: When two or more lanes hold the smallest value, the reported lane number is the lowest of them.
- R6: An operand sampled with `in_valid` high in cycle c produces `out_valid` high and its result in cycle c+3, and at no other cycle.
- R7: Operands presented on consecutive cycles produce results on consecutive cycles, in the same order.
- R8: `out_valid` stays low in every cycle whose input three cycles earlier had `in_valid` low.
- R9: While `rst_n` is low, `out_valid` and `out_res` read zero, and operands that were in flight when reset was applied produce no result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_src | input | 128 | Eight unsigned 16-bit lanes |
| out_valid | output | 1 | Result strobe |
| out_res | output | 128 | Packed result: value in 15:0, lane number in 31:16, zeros above |

## Verification
Every result is due in the third cycle after the cycle in which its operand was strobed. The bench changes inputs and samples outputs only at the falling edge. It keeps a three-slot queue of expected strobes and results, which advances once per cycle, so each comparison lands exactly in the cycle where the answer must appear. The same queue expects `out_valid` low in every cycle that follows an idle input, and that covers gaps and the cycles after reset. The checker module holds its own three-cycle history of strobes and operands, so its properties compare the output with the operand that was presented three cycles before.

// File: rtl/minpos_pkg.sv
`timescale 1ns/1ps
package minpos_pkg;
    localparam int LANE_W = 16;
    localparam int LANES  = 8;
    localparam int IDX_W  = $clog2(LANES);
    localparam int LEVELS = $clog2(LANES);
    localparam int DATA_W = LANE_W * LANES;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [LANE_W-1:0] val;
    } cand_t;
endpackage

// File: rtl/minpos_pick.sv
`timescale 1ns/1ps
// One tree node: the lower-numbered candidate wins unless the other is strictly smaller.
module minpos_pick
    import minpos_pkg::*;
(
    input  cand_t lo_i,
    input  cand_t hi_i,
    output cand_t win_o
);
    always_comb begin
        if (hi_i.val < lo_i.val) begin
            win_o = hi_i;
        end else begin
            win_o = lo_i;
        end
    end
endmodule

// File: rtl/minpos_stage.sv
`timescale 1ns/1ps
// One registered tree level: halves the number of candidates.
module minpos_stage
    import minpos_pkg::*;
#(
    parameter  int NIN  = 8,
    localparam int NOUT = NIN / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  cand_t [NIN-1:0]  c_i,
    output logic             vld_o,
    output cand_t [NOUT-1:0] c_o
);
    typedef struct packed {
        logic             vld;
        cand_t [NOUT-1:0] c;
    } stage_t;

    stage_t           st_d, st_q;
    cand_t [NOUT-1:0] win;

    for (genvar j = 0; j < NOUT; j++) begin : g_node
        minpos_pick u_pick (
            .lo_i  (c_i[2*j]),
            .hi_i  (c_i[2*j+1]),
            .win_o (win[j])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = vld_i;
        if (vld_i) begin
            st_d.c = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign c_o   = st_q.c;
endmodule

// File: rtl/minpos_unit.sv
`timescale 1ns/1ps
module minpos_unit
    import minpos_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_src,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_res
);
    cand_t [LANES-1:0] lane_c;
    cand_t             fin_c;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_c[i].idx = IDX_W'(i);
        assign lane_c[i].val = in_src[i*LANE_W +: LANE_W];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int NIN = LANES >> l;
        cand_t [NIN-1:0]   c_in;
        cand_t [NIN/2-1:0] c_out;
        logic              v_in;
        logic              v_out;

        if (l == 0) begin : g_src
            assign c_in = lane_c;
            assign v_in = in_valid;
        end else begin : g_chain
            assign c_in = g_lvl[l-1].c_out;
            assign v_in = g_lvl[l-1].v_out;
        end

        minpos_stage #(.NIN(NIN)) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (v_in),
            .c_i   (c_in),
            .vld_o (v_out),
            .c_o   (c_out)
        );
    end

    assign fin_c     = g_lvl[LEVELS-1].c_out[0];
    assign out_valid = g_lvl[LEVELS-1].v_out;

    always_comb begin
        out_res                      = '0;
        out_res[LANE_W-1:0]          = fin_c.val;
        out_res[LANE_W +: IDX_W]     = fin_c.idx;
    end
endmodule

// File: rtl/minpos_chk.sv
`timescale 1ns/1ps
module minpos_chk
    import minpos_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [DATA_W-1:0] in_src,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_res
);
    logic [LEVELS-1:0] v_hist;
    logic [DATA_W-1:0] s_hist [LEVELS];
    logic [DATA_W-1:0] old_src;
    logic [LANE_W-1:0] rep_val;
    logic [IDX_W-1:0]  rep_idx;
    logic [LANE_W-1:0] lane;
    logic              all_ge, idx_hit, none_before;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_hist <= '0;
        end else begin
            v_hist <= (v_hist << 1) | LEVELS'(in_valid);
        end
    end

    always_ff @(posedge clk) begin
        s_hist[0] <= in_src;
        for (int k = 1; k < LEVELS; k++) begin
            s_hist[k] <= s_hist[k-1];
        end
    end

    always_comb begin
        old_src     = s_hist[LEVELS-1];
        rep_val     = out_res[LANE_W-1:0];
        rep_idx     = out_res[LANE_W +: IDX_W];
        all_ge      = 1'b1;
        idx_hit     = 1'b1;
        none_before = 1'b1;
        lane        = '0;
        for (int i = 0; i < LANES; i++) begin
            lane = old_src[i*LANE_W +: LANE_W];
            if (lane < rep_val) all_ge = 1'b0;
            if (IDX_W'(i) == rep_idx && lane != rep_val) idx_hit = 1'b0;
            if (IDX_W'(i) < rep_idx && lane == rep_val) none_before = 1'b0;
        end
    end

    // R6, R8
    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_hist[LEVELS-1]);
    // R2
    p_min_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> all_ge);
    // R3
    p_index_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (idx_hit && out_res[2*LANE_W-1:LANE_W+IDX_W] == '0));
    // R4
    p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res[DATA_W-1:2*LANE_W] == '0));
    // R5
    p_lowest_tie_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> none_before);
    // R9
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_clear_r9: assert (!out_valid && out_res == '0);
        end
    end
endmodule

bind minpos_unit minpos_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_src    (in_src),
    .out_valid (out_valid),
    .out_res   (out_res)
);

// File: tb/minpos_unit_tb.sv
`timescale 1ns/1ps
module minpos_unit_tb;
    localparam int NVEC = 10;

    localparam logic [127:0] VEC_SRC [NVEC] = '{
        128'h0000_0000_0000_0000_0000_0000_0000_0000,
        128'h0001_0002_0003_0004_0005_0006_0007_0008,
        128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_FFFF_FFFF_0001_FFFF_FFFF_FFFF,
        128'hFFFF_FFFF_7FFF_FFFF_FFFF_FFFF_FFFF_8000,
        128'h5000_1234_5000_5000_5000_1234_5000_5000,
        128'h0008_0007_0006_0005_0004_0003_0002_0001,
        128'h0000_0001_0001_0001_0001_0001_0001_0001,
        128'hABCD_0010_ABCD_0010_ABCD_ABCD_0011_ABCD,
        128'h0005_0006_0006_0006_0006_0006_0006_0005
    };
    localparam logic [31:0] VEC_EXP [NVEC] = '{
        32'h0000_0000, 32'h0007_0001, 32'h0000_FFFF, 32'h0003_0001,
        32'h0005_7FFF, 32'h0002_1234, 32'h0000_0001, 32'h0007_0000,
        32'h0004_0010, 32'h0000_0005
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [127:0] in_src = '0;
    logic         out_valid;
    logic [127:0] out_res;

    int n_chk  = 0;
    int n_fail = 0;

    logic         exp_v [3];
    logic [31:0]  exp_r [3];
    string        exp_t [3];

    always #10 clk = ~clk;

    minpos_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_src    (in_src),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_min(input logic [127:0] s);
        logic [15:0] best;
        logic [15:0] bi;
        best = s[15:0];
        bi   = 16'd0;
        for (int i = 1; i < 8; i++) begin
            if (s[i*16 +: 16] < best) begin
                best = s[i*16 +: 16];
                bi   = 16'(i);
            end
        end
        return {bi, best};
    endfunction

    task automatic clear_queue();
        for (int k = 0; k < 3; k++) begin
            exp_v[k] = 1'b0;
            exp_r[k] = '0;
            exp_t[k] = "";
        end
    endtask

    // One cycle: check the slot due now, then drive the next operand.
    task automatic step(input logic v, input logic [127:0] src, input logic [31:0] exp,
                        input string tag);
        @(negedge clk);
        check(out_valid == exp_v[2], {"R6 R8 strobe ", exp_t[2]},
              128'(out_valid), 128'(exp_v[2]));
        if (exp_v[2]) begin
            check(out_res[15:0] == exp_r[2][15:0], {"R2 value ", exp_t[2]},
                  128'(out_res[15:0]), 128'(exp_r[2][15:0]));
            check(out_res[31:16] == exp_r[2][31:16], {"R3 lane ", exp_t[2]},
                  128'(out_res[31:16]), 128'(exp_r[2][31:16]));
            check(out_res[127:32] == '0, {"R4 upper ", exp_t[2]},
                  128'(out_res[127:32]), 128'h0);
        end
        exp_v[2] = exp_v[1]; exp_r[2] = exp_r[1]; exp_t[2] = exp_t[1];
        exp_v[1] = exp_v[0]; exp_r[1] = exp_r[0]; exp_t[1] = exp_t[0];
        exp_v[0] = v;        exp_r[0] = exp;      exp_t[0] = tag;
        in_valid = v;
        in_src   = src;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, '0, '0, "idle");
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [127:0] rs;
        clear_queue();
        // R9: state while reset is held
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R9 reset strobe", 128'(out_valid), 128'h0);
        check(out_res == '0, "R9 reset result", out_res, 128'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: table walked back to back; R5 ties in vectors 0, 5, 8, 9
        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VEC_SRC[i], VEC_EXP[i],
                 (i == 0 || i == 5 || i == 8 || i == 9) ? "R5 tie" : "R7 stream");
        end
        idle(4);

        // R6 and R8: a single strobe surrounded by idle cycles
        step(1'b1, 128'hFFFF_FFFF_FFFF_0002_FFFF_FFFF_FFFF_FFFF, 32'h0004_0002, "R6 single");
        idle(5);

        // R1: random operands, narrow values force frequent ties (R5)
        for (int i = 0; i < 40; i++) begin
            for (int j = 0; j < 8; j++) begin
                rs[j*16 +: 16] = (i % 2 == 0) ? 16'($urandom) : 16'($urandom & 3);
            end
            step((i % 5) != 3, rs, ref_min(rs), "R1 random");
        end
        idle(4);

        // R9: reset in the middle of a burst drops work in flight
        step(1'b1, VEC_SRC[1], VEC_EXP[1], "R9 flight");
        step(1'b1, VEC_SRC[3], VEC_EXP[3], "R9 flight");
        @(negedge clk);
        rst_n = 1'b0;
        clear_queue();
        #1;
        check(out_valid == 1'b0, "R9 mid reset strobe", 128'(out_valid), 128'h0);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b1;
        idle(5);

        // R2 after recovery: extreme value alone
        step(1'b1, 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFE, 32'h0000_FFFE, "R2 edge");
        idle(4);
        finish_run();
    end
endmodule